// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of a general-purpose I/O controller. The bank width is a parameter. Each pin can drive its pad, or it can be observed as an input. Three configuration bits per pin choose how an input raises an interrupt event: rising edge, falling edge, either edge, high level or low level. Pad inputs pass through a multi-flop synchronizer before detection. Edges are found by comparing the synchronized value with the value from one cycle earlier.

Events are latched into a per-pin status register. Software clears status one pin at a time by writing ones. A mask register decides which pending pins reach the single combined interrupt line. All registers are reached through a flat register port: a write strobe, an address and write data, with read data returned combinationally from the same address. Gathering several banks together and adapting to a system bus are left to the surrounding logic.

Top module: `gpio_irq_bank`

## Requirements
- R1: A pin with trig_edge=1, trig_pol=1 and trig_both=0 sets its status bit on a 0-to-1 change of its synchronized input. A 1-to-0 change does not set it.
- R2: A pin with trig_edge=1, trig_pol=0 and trig_both=0 sets its status bit on a 1-to-0 change of its synchronized input. A 0-to-1 change does not set it.
- R3: A pin with trig_edge=1 and trig_both=1 sets its status bit on every change of its input, whatever the value of trig_pol.
- R4: A pin with trig_edge=0 sets its status bit in every cycle in which its synchronized input equals trig_pol, whatever the value of trig_both. A clear issued while that level is still present leaves the bit set.
- R5: irq is 1 exactly when at least one pin has its status bit set and its mask bit clear. A pin whose mask bit is 1 never raises irq.
- R6: Writing the status address clears each status bit whose write-data bit is 1. Bits written with 0 keep their value, and no status bit falls without such a write.
- R7: When a new event and a clear reach the same pin at the same clock edge, the status bit stays 1.
- R8: A pad change shows in the status register after the third rising clock edge that follows it, and not after the second.
- R9: pad_oe of a pin is 1 only when both its direction bit and its output-enable bit are 1. pad_out carries the output-data register.
- R10: After reset: direction, output enable and output data are 0, mask is all ones, status is 0, and trig_edge=1, trig_pol=1, trig_both=0 (rising-edge mode) on every pin.
- R11: Register addresses: 0 direction, 1 output enable, 2 output data, 3 synchronized pad input (read only), 4 trig_edge, 5 trig_pol, 6 trig_both, 7 mask, 8 status. A read returns the register at the address presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | PINS | Register write data |
| rdata | output | PINS | Register read data for addr |
| pad_in | input | PINS | Asynchronous pad inputs |
| pad_out | output | PINS | Output data toward the pads |
| pad_oe | output | PINS | Per-pin pad drive enable |
| irq | output | 1 | Combined interrupt for unmasked pending pins |

## Verification
A register write takes effect at the first rising edge after the strobe is driven. Read data and pad_oe follow combinationally, so the bench reads them in the low phase right after that edge. A pad change passes two synchronizer edges, and the status bit latches at the third edge. The bench drives the pad on a falling edge, confirms status is still clear after two rising edges, and checks it after the third. irq is a combinational function of status and mask, so it is sampled in the same low phase as status. For the collision case, the clear strobe is placed so that it is present at exactly the third edge, which is where the event lands.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Register addresses of one bank
   localparam int unsigned ADR_DIR   = 0;
   localparam int unsigned ADR_OEN   = 1;
   localparam int unsigned ADR_DOUT  = 2;
   localparam int unsigned ADR_DIN   = 3;
   localparam int unsigned ADR_EDGE  = 4;
   localparam int unsigned ADR_POL   = 5;
   localparam int unsigned ADR_BOTH  = 6;
   localparam int unsigned ADR_MASK  = 7;
   localparam int unsigned ADR_STAT  = 8;
   localparam int unsigned ADR_COUNT = 9;

   // Smallest address width that reaches every register
   localparam int unsigned ADR_MIN_W = $clog2(ADR_COUNT);

   // Per-pin trigger choice after decoding the three configuration bits
   typedef enum logic [2:0] {
      TRIG_RISE = 3'd0,
      TRIG_FALL = 3'd1,
      TRIG_ANY  = 3'd2,
      TRIG_HIGH = 3'd3,
      TRIG_LOW  = 3'd4
   } trig_mode_e;

   function automatic trig_mode_e decode_trig(input logic is_edge,
                                              input logic pol,
                                              input logic both);
      trig_mode_e m;
      if (is_edge) begin
         if (both)     m = TRIG_ANY;
         else if (pol) m = TRIG_RISE;
         else          m = TRIG_FALL;
      end else begin
         if (pol)      m = TRIG_HIGH;
         else          m = TRIG_LOW;
      end
      return m;
   endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_bank_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= '0;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect
   import gpio_bank_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sync_in,
   input  logic [W-1:0] trig_edge,
   input  logic [W-1:0] trig_pol,
   input  logic [W-1:0] trig_both,
   output logic [W-1:0] evt
);

   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= sync_in;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      trig_mode_e mode;
      logic       rise;
      logic       fall;

      assign mode = decode_trig(trig_edge[i], trig_pol[i], trig_both[i]);
      assign rise = sync_in[i] & ~prev[i];
      assign fall = ~sync_in[i] & prev[i];

      always_comb begin
         unique case (mode)
            TRIG_RISE: evt[i] = rise;
            TRIG_FALL: evt[i] = fall;
            TRIG_ANY:  evt[i] = rise | fall;
            TRIG_HIGH: evt[i] = sync_in[i];
            TRIG_LOW:  evt[i] = ~sync_in[i];
            default:   evt[i] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned W      = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   input  logic [W-1:0]      evt,
   input  logic [W-1:0]      din,
   output logic [W-1:0]      rdata,
   output logic [W-1:0]      dir,
   output logic [W-1:0]      oen,
   output logic [W-1:0]      dout,
   output logic [W-1:0]      trig_edge,
   output logic [W-1:0]      trig_pol,
   output logic [W-1:0]      trig_both,
   output logic [W-1:0]      mask,
   output logic [W-1:0]      status
);

   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(ADR_DIR);
   localparam logic [ADDR_W-1:0] A_OEN  = ADDR_W'(ADR_OEN);
   localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(ADR_DOUT);
   localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(ADR_DIN);
   localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(ADR_EDGE);
   localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(ADR_POL);
   localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'(ADR_BOTH);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADR_MASK);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

   logic [W-1:0] clr;

   assign clr = (wr_en && addr == A_STAT) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir       <= '0;
         oen       <= '0;
         dout      <= '0;
         trig_edge <= '1;
         trig_pol  <= '1;
         trig_both <= '0;
         mask      <= '1;
      end else if (wr_en) begin
         unique case (addr)
            A_DIR:   dir       <= wdata;
            A_OEN:   oen       <= wdata;
            A_DOUT:  dout      <= wdata;
            A_EDGE:  trig_edge <= wdata;
            A_POL:   trig_pol  <= wdata;
            A_BOTH:  trig_both <= wdata;
            A_MASK:  mask      <= wdata;
            default: ;
         endcase
      end
   end

   // New events take priority over a clear on the same pin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr) | evt;
   end

   always_comb begin
      unique case (addr)
         A_DIR:   rdata = dir;
         A_OEN:   rdata = oen;
         A_DOUT:  rdata = dout;
         A_DIN:   rdata = din;
         A_EDGE:  rdata = trig_edge;
         A_POL:   rdata = trig_pol;
         A_BOTH:  rdata = trig_both;
         A_MASK:  rdata = mask;
         A_STAT:  rdata = status;
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS        = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PINS-1:0]   wdata,
   output logic [PINS-1:0]   rdata,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe,
   output logic              irq
);

   if (PINS < 1 || PINS > 32) begin : g_bad_pins
      $error("gpio_irq_bank: PINS must lie in 1..32");
   end
   if (ADDR_W < ADR_MIN_W) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W too narrow for the register map");
   end

   logic [PINS-1:0] din_sync;
   logic [PINS-1:0] evt;
   logic [PINS-1:0] dir, oen, dout;
   logic [PINS-1:0] trig_edge, trig_pol, trig_both;
   logic [PINS-1:0] mask, status;

   gpio_bank_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (din_sync)
   );

   gpio_bank_detect #(.W(PINS)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (din_sync),
      .trig_edge (trig_edge),
      .trig_pol  (trig_pol),
      .trig_both (trig_both),
      .evt       (evt)
   );

   gpio_bank_regs #(.W(PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .evt       (evt),
      .din       (din_sync),
      .rdata     (rdata),
      .dir       (dir),
      .oen       (oen),
      .dout      (dout),
      .trig_edge (trig_edge),
      .trig_pol  (trig_pol),
      .trig_both (trig_both),
      .mask      (mask),
      .status    (status)
   );

   assign pad_out = dout;
   assign pad_oe  = dir & oen;
   assign irq     = |(status & ~mask);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS   = 8,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [PINS-1:0]   wdata,
   input logic [PINS-1:0]   evt,
   input logic [PINS-1:0]   status,
   input logic [PINS-1:0]   mask,
   input logic              irq
);

   logic stat_wr;
   assign stat_wr = wr_en && (addr == ADDR_W'(ADR_STAT));

   // R7: a detected event is latched at the next edge, even under a clear
   a_r7_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

   // R6: bits written with 1 and without a new event are cleared
   a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((status & $past(wdata) & ~$past(evt)) == '0));

   // R6: without a status write no bit falls
   a_r6_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((status & $past(status)) == $past(status)));

   // R5: a fully masked bank keeps the interrupt low
   a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '1) |-> !irq);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .evt    (evt),
   .status (status),
   .mask   (mask),
   .irq    (irq)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;

   localparam int P = 8;
   localparam logic [3:0] A_DIR = 0, A_OEN = 1, A_DOUT = 2, A_DIN = 3,
                          A_EDGE = 4, A_POL = 5, A_BOTH = 6, A_MASK = 7, A_STAT = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   addr = '0;
   logic [P-1:0] wdata = '0;
   logic [P-1:0] rdata;
   logic [P-1:0] pad_in = '0;
   logic [P-1:0] pad_out;
   logic [P-1:0] pad_oe;
   logic         irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_irq_bank #(.PINS(P), .ADDR_W(4), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [P-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [P-1:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic expect_reg(input string req, input logic [3:0] a, input logic [P-1:0] e);
      logic [P-1:0] v;
      rd(a, v);
      chk(req, 32'(v), 32'(e));
   endtask

   task automatic t_reset_state();
      expect_reg("R10 dir", A_DIR, 8'h00);
      expect_reg("R10 oen", A_OEN, 8'h00);
      expect_reg("R10 dout", A_DOUT, 8'h00);
      expect_reg("R10 mask", A_MASK, 8'hFF);
      expect_reg("R10 status", A_STAT, 8'h00);
      expect_reg("R10 edge", A_EDGE, 8'hFF);
      expect_reg("R10 pol", A_POL, 8'hFF);
      expect_reg("R10 both", A_BOTH, 8'h00);
      chk("R10 pad_oe", 32'(pad_oe), 32'h0);
      chk("R10 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_rise();
      pad_in[0] = 1'b1;
      tick(2);
      expect_reg("R8 not yet after two edges", A_STAT, 8'h00);
      tick(1);
      expect_reg("R8 R1 rise latched after third edge", A_STAT, 8'h01);
      wr(A_STAT, 8'h01);
      expect_reg("R6 cleared", A_STAT, 8'h00);
      pad_in[0] = 1'b0;
      tick(4);
      expect_reg("R1 fall ignored in rise mode", A_STAT, 8'h00);
   endtask

   task automatic t_fall();
      wr(A_POL, 8'hFB);
      pad_in[2] = 1'b1;
      tick(4);
      expect_reg("R2 rise ignored in fall mode", A_STAT, 8'h00);
      pad_in[2] = 1'b0;
      tick(3);
      expect_reg("R2 fall latched", A_STAT, 8'h04);
      wr(A_STAT, 8'h00);
      expect_reg("R6 zero write no effect", A_STAT, 8'h04);
      wr(A_STAT, 8'h04);
      expect_reg("R6 clear pin2", A_STAT, 8'h00);
      wr(A_POL, 8'hFF);
   endtask

   task automatic t_both();
      wr(A_BOTH, 8'h08);
      pad_in[3] = 1'b1; tick(3);
      expect_reg("R3 rise in any mode", A_STAT, 8'h08);
      wr(A_STAT, 8'h08);
      pad_in[3] = 1'b0; tick(3);
      expect_reg("R3 fall in any mode", A_STAT, 8'h08);
      wr(A_STAT, 8'h08);
      wr(A_POL, 8'hF7);
      pad_in[3] = 1'b1; tick(3);
      expect_reg("R3 polarity ignored", A_STAT, 8'h08);
      wr(A_STAT, 8'h08);
      pad_in[3] = 1'b0; tick(3);
      wr(A_STAT, 8'h08);
      wr(A_POL, 8'hFF);
      expect_reg("R3 cleanup", A_STAT, 8'h00);
   endtask

   task automatic t_ack_independent();
      pad_in[0] = 1'b1; pad_in[3] = 1'b1;
      tick(3);
      expect_reg("R6 two pending", A_STAT, 8'h09);
      wr(A_STAT, 8'h01);
      expect_reg("R6 other pin untouched", A_STAT, 8'h08);
      wr(A_STAT, 8'h08);
      pad_in[0] = 1'b0; pad_in[3] = 1'b0;
      tick(3);
      wr(A_STAT, 8'hFF);
      expect_reg("R6 clear all", A_STAT, 8'h00);
   endtask

   task automatic t_level();
      wr(A_EDGE, 8'hFD);
      tick(3);
      expect_reg("R4 high level idle", A_STAT, 8'h00);
      pad_in[1] = 1'b1; tick(3);
      expect_reg("R4 high level latched", A_STAT, 8'h02);
      wr(A_STAT, 8'h02);
      expect_reg("R4 clear while active keeps bit", A_STAT, 8'h02);
      pad_in[1] = 1'b0; tick(3);
      wr(A_STAT, 8'h02);
      expect_reg("R4 clear after level gone", A_STAT, 8'h00);
      wr(A_BOTH, 8'h0A);
      wr(A_POL, 8'hFD);
      tick(1);
      expect_reg("R4 low level, any bit ignored", A_STAT, 8'h02);
      wr(A_EDGE, 8'hFF);
      wr(A_POL, 8'hFF);
      wr(A_BOTH, 8'h00);
      wr(A_STAT, 8'hFF);
      expect_reg("R4 cleanup", A_STAT, 8'h00);
   endtask

   task automatic t_irq_mask();
      pad_in[0] = 1'b1; tick(3);
      expect_reg("R5 pending", A_STAT, 8'h01);
      chk("R5 masked pin blocks irq", 32'(irq), 32'h0);
      wr(A_MASK, 8'hFD);
      chk("R5 masked other pin, still quiet", 32'(irq), 32'h0);
      wr(A_MASK, 8'hFE);
      chk("R5 unmasked pending raises irq", 32'(irq), 32'h1);
      wr(A_STAT, 8'h01);
      chk("R5 irq drops after clear", 32'(irq), 32'h0);
      wr(A_MASK, 8'hFF);
      pad_in[0] = 1'b0; tick(3);
   endtask

   task automatic t_event_wins();
      pad_in[0] = 1'b1; tick(3);
      expect_reg("R7 first event", A_STAT, 8'h01);
      pad_in[0] = 1'b0; tick(3);
      pad_in[0] = 1'b1; tick(2);
      wr(A_STAT, 8'h01);
      expect_reg("R7 event beats clear", A_STAT, 8'h01);
      wr(A_STAT, 8'h01);
      expect_reg("R7 later clear works", A_STAT, 8'h00);
      pad_in[0] = 1'b0; tick(3);
   endtask

   task automatic t_pad_drive();
      wr(A_DIR, 8'h05);
      wr(A_OEN, 8'h06);
      wr(A_DOUT, 8'hA5);
      chk("R9 oe needs dir and enable", 32'(pad_oe), 32'h04);
      chk("R9 pad_out data", 32'(pad_out), 32'hA5);
      wr(A_DIR, 8'h00);
      chk("R9 input direction disables drive", 32'(pad_oe), 32'h00);
   endtask

   task automatic t_readback();
      pad_in = 8'h5A; tick(3);
      expect_reg("R11 synchronized pad input", A_DIN, 8'h5A);
      wr(A_BOTH, 8'h3C);
      expect_reg("R11 any-edge readback", A_BOTH, 8'h3C);
      wr(A_BOTH, 8'h00);
      pad_in = 8'h00; tick(3);
      wr(A_STAT, 8'hFF);
      expect_reg("R11 unmapped address reads 0", 4'hF, 8'h00);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset_state();
      t_rise();
      t_fall();
      t_both();
      t_ack_independent();
      t_level();
      t_irq_mask();
      t_event_wins();
      t_pad_drive();
      t_readback();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule